// File: doc/BRIEF.md
# External Interrupt Router for Four Cores

The router takes a parameterised set of level-sensitive interrupt lines and delivers each one to a single core out of four, and to one of four interrupt pins on that core. It is a two-level routing scheme. Each group of 32 lines shares one pin choice, and each individual line carries its own core choice. Both choices are one-hot bytes in software-visible map words. A line that is both pending and enabled sets a status bit in the status copy of its target core. Each core-and-pin output is high while any status bit routed to it is set.

Software reaches the router through a flat 32-bit word interface. A requester-core number picks which core's status copy a status access sees. Writing the enable words re-evaluates lines that are already pending. Rewriting the core map moves pending lines from the old core to the new one. Two further sets of words are plain read/write storage with no effect on routing.

Top module: `ext_irq_router`

## Requirements
- R1: After synchronous reset every output is 0 and every word reads 0.
- R2: Line i belongs to group i/32 at bit i mod 32. The enable word for group g is at byte address 0x100+4g. The status word for group g is at 0x400+4g.
- R3: Pin-map words are at 0x200+4w, and byte b (little-endian) of word w selects the pin of group 4w+b. The selected pin is the index of the lowest set bit. An index of 4 or more, or a zero byte, selects pin 0.
- R4: Core-map words are at 0x800+4w, and byte b selects the core of line 4w+b with the same lowest-set-bit decode. An index of 4 or more, or a zero byte, selects core 0.
- R5: A rising line marks it pending. It sets the target core's status bit only if the line's enable bit is 1. Output bit core*4+pin rises at the first clock edge after the change.
- R6: A falling line clears its pending state and its status bit, and its contribution to the output goes away one clock later.
- R7: An output stays high while at least one routed status bit is set, and falls only when the last one clears.
- R8: An enable write that sets the bit of a pending line raises that line at its target. A write that clears the bit lowers the line.
- R9: Status words are write-1-to-clear and act only on the copy named by the requester core. Other cores' copies are untouched.
- R10: Rewriting a pending line's core selection lowers it at the old core and raises it at the new core, provided the line is enabled.
- R11: Words at 0x300+4g and node words at 0x000–0x00C read back what was written and do not affect outputs. Unmapped addresses read 0.
- R12: When a rising line and a clearing write hit the same status bit in the same cycle, the line wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IRQ | Level-sensitive interrupt lines |
| reg_addr | input | 12 | Word-aligned byte address |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_core | input | 2 | Requester core for status accesses |
| reg_rdata | output | 32 | Combinational read data |
| irq_out | output | 16 | Per core/pin interrupt, bit core*4+pin |

## Verification
The hardest cases to reach are those where a register write acts on a line that is already pending. These are an enable bit being set or cleared under an asserted line, and a core-map rewrite that moves an asserted line to another core. The stimulus raises the line first, checks where it landed, and only then issues the write. A single negedge both raises a line and issues a clearing write to the same status bit, which exercises the same-cycle race.

// File: rtl/exir_pkg.sv
package exir_pkg;

    localparam int CORES    = 4;
    localparam int PINS     = 4;
    localparam int GRP_BITS = 32;

    typedef logic [1:0] sel_t;

    typedef enum logic [2:0] {
        RG_NONE, RG_NODE, RG_EN, RG_PMAP, RG_BNC, RG_STAT, RG_CMAP
    } region_e;

    typedef struct packed {
        region_e    rg;
        logic [9:0] idx;
    } dec_t;

    // word-address bases of the windows
    localparam logic [9:0] EN_BASE   = 10'h040;
    localparam logic [9:0] PMAP_BASE = 10'h080;
    localparam logic [9:0] BNC_BASE  = 10'h0C0;
    localparam logic [9:0] STAT_BASE = 10'h100;
    localparam logic [9:0] CMAP_BASE = 10'h200;

    // lowest set bit of a one-hot selection byte; out of range falls back to 0
    function automatic sel_t byte_to_sel(input logic [7:0] b);
        casez (b[3:0])
            4'b???1: return 2'd0;
            4'b??10: return 2'd1;
            4'b?100: return 2'd2;
            4'b1000: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic dec_t decode(input logic [9:0] w, input int grp,
                                    input int pmw, input int cmw, input int nw);
        dec_t r;
        r.rg  = RG_NONE;
        r.idx = '0;
        if (w < 10'(nw)) begin
            r.rg = RG_NODE;  r.idx = w;
        end else if (w >= EN_BASE && w < EN_BASE + 10'(grp)) begin
            r.rg = RG_EN;    r.idx = w - EN_BASE;
        end else if (w >= PMAP_BASE && w < PMAP_BASE + 10'(pmw)) begin
            r.rg = RG_PMAP;  r.idx = w - PMAP_BASE;
        end else if (w >= BNC_BASE && w < BNC_BASE + 10'(grp)) begin
            r.rg = RG_BNC;   r.idx = w - BNC_BASE;
        end else if (w >= STAT_BASE && w < STAT_BASE + 10'(grp)) begin
            r.rg = RG_STAT;  r.idx = w - STAT_BASE;
        end else if (w >= CMAP_BASE && w < CMAP_BASE + 10'(cmw)) begin
            r.rg = RG_CMAP;  r.idx = w - CMAP_BASE;
        end
        return r;
    endfunction

endpackage

// File: rtl/exir_regs.sv
module exir_regs
    import exir_pkg::*;
#(
    parameter int N_IRQ      = 256,
    parameter int NODE_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [11:0]                   reg_addr,
    input  logic                          reg_wen,
    input  logic [31:0]                   reg_wdata,
    input  sel_t                          reg_core,
    input  logic [CORES-1:0][N_IRQ-1:0]   st_q,
    output logic [N_IRQ-1:0]              en_q,
    output logic [N_IRQ-1:0]              en_d,
    output sel_t [N_IRQ-1:0]              tgt_q,
    output sel_t [N_IRQ-1:0]              tgt_d,
    output sel_t [N_IRQ/GRP_BITS-1:0]     pin,
    output logic                          clr_vld,
    output logic [N_IRQ-1:0]              clr_mask,
    output logic [31:0]                   reg_rdata
);
    localparam int GRPS = N_IRQ / GRP_BITS;
    localparam int PMW  = (GRPS + 3) / 4;
    localparam int CMW  = N_IRQ / 4;

    logic [N_IRQ*8-1:0]        cm_q, cm_d;
    logic [PMW*32-1:0]         pm_q;
    logic [GRPS*32-1:0]        bn_q;
    logic [NODE_WORDS*32-1:0]  nt_q;
    dec_t                      dec;
    logic                      unused_lsb;

    assign unused_lsb = ^reg_addr[1:0];
    assign dec = decode(reg_addr[11:2], GRPS, PMW, CMW, NODE_WORDS);

    always_comb begin
        en_d = en_q;
        cm_d = cm_q;
        if (reg_wen && dec.rg == RG_EN)   en_d[dec.idx*32 +: 32] = reg_wdata;
        if (reg_wen && dec.rg == RG_CMAP) cm_d[dec.idx*32 +: 32] = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            cm_q <= '0;
            pm_q <= '0;
            bn_q <= '0;
            nt_q <= '0;
        end else begin
            en_q <= en_d;
            cm_q <= cm_d;
            if (reg_wen && dec.rg == RG_PMAP) pm_q[dec.idx*32 +: 32] <= reg_wdata;
            if (reg_wen && dec.rg == RG_BNC)  bn_q[dec.idx*32 +: 32] <= reg_wdata;
            if (reg_wen && dec.rg == RG_NODE) nt_q[dec.idx*32 +: 32] <= reg_wdata;
        end
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_core_sel
        assign tgt_q[i] = byte_to_sel(cm_q[i*8 +: 8]);
        assign tgt_d[i] = byte_to_sel(cm_d[i*8 +: 8]);
    end

    for (genvar g = 0; g < GRPS; g++) begin : g_pin_sel
        assign pin[g] = byte_to_sel(pm_q[g*8 +: 8]);
    end

    assign clr_vld = reg_wen && dec.rg == RG_STAT;

    always_comb begin
        clr_mask = '0;
        if (clr_vld) clr_mask[dec.idx*32 +: 32] = reg_wdata;
    end

    always_comb begin
        case (dec.rg)
            RG_NODE: reg_rdata = nt_q[dec.idx*32 +: 32];
            RG_EN:   reg_rdata = en_q[dec.idx*32 +: 32];
            RG_PMAP: reg_rdata = pm_q[dec.idx*32 +: 32];
            RG_BNC:  reg_rdata = bn_q[dec.idx*32 +: 32];
            RG_STAT: reg_rdata = st_q[reg_core][dec.idx*32 +: 32];
            RG_CMAP: reg_rdata = cm_q[dec.idx*32 +: 32];
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/exir_status.sv
module exir_status
    import exir_pkg::*;
#(
    parameter int N_IRQ = 256
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_IRQ-1:0]              irq_in,
    input  logic [N_IRQ-1:0]              en_q,
    input  logic [N_IRQ-1:0]              en_d,
    input  sel_t [N_IRQ-1:0]              tgt_q,
    input  sel_t [N_IRQ-1:0]              tgt_d,
    input  logic                          clr_vld,
    input  sel_t                          clr_core,
    input  logic [N_IRQ-1:0]              clr_mask,
    output logic [CORES-1:0][N_IRQ-1:0]   st_q,
    output logic [CORES-1:0][N_IRQ-1:0]   st_d
);
    logic [N_IRQ-1:0]            pend_q;
    logic [N_IRQ-1:0]            rise, fall;
    logic [CORES-1:0][N_IRQ-1:0] on_q, on_d;

    assign rise = irq_in & ~pend_q;
    assign fall = ~irq_in & pend_q;

    always_comb begin
        for (int c = 0; c < CORES; c++) begin
            for (int i = 0; i < N_IRQ; i++) begin
                on_q[c][i] = (tgt_q[i] == sel_t'(c));
                on_d[c][i] = (tgt_d[i] == sel_t'(c));
            end
        end
    end

    // ordering: clearing write, enable edges, move, then line edges (line wins)
    always_comb begin
        for (int c = 0; c < CORES; c++) begin
            for (int i = 0; i < N_IRQ; i++) begin
                st_d[c][i] = st_q[c][i];
                if (clr_vld && clr_core == sel_t'(c) && clr_mask[i])
                    st_d[c][i] = 1'b0;
                if (pend_q[i] && en_d[i] && !en_q[i] && on_q[c][i])
                    st_d[c][i] = 1'b1;
                if (pend_q[i] && !en_d[i] && en_q[i] && on_q[c][i])
                    st_d[c][i] = 1'b0;
                if (pend_q[i] && tgt_d[i] != tgt_q[i]) begin
                    if (on_q[c][i])              st_d[c][i] = 1'b0;
                    if (on_d[c][i] && en_d[i])   st_d[c][i] = 1'b1;
                end
                if (rise[i] && en_d[i] && on_d[c][i]) st_d[c][i] = 1'b1;
                if (fall[i] && on_d[c][i])            st_d[c][i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            st_q   <= '0;
        end else begin
            pend_q <= irq_in;
            st_q   <= st_d;
        end
    end

    for (genvar c = 0; c < CORES; c++) begin : g_chk
        // R10: a status bit only lives at the line's current core, pending and enabled
        p_status_home_r10: assert property (@(posedge clk) disable iff (rst)
            (st_q[c] & ~(pend_q & en_q & on_q[c])) == '0);

        p_clear_takes_r9: assert property (@(posedge clk) disable iff (rst)
            (clr_vld && clr_core == sel_t'(c)) |=> (st_q[c] & $past(clr_mask & ~rise)) == '0);

        p_rise_sets_r5: assert property (@(posedge clk) disable iff (rst)
            (|(rise & en_d & on_d[c])) |=> ($past(rise & en_d & on_d[c]) & ~st_q[c]) == '0);

        p_fall_clears_r6: assert property (@(posedge clk) disable iff (rst)
            (|fall) |=> (st_q[c] & $past(fall)) == '0);
    end

endmodule

// File: rtl/exir_fanin.sv
module exir_fanin
    import exir_pkg::*;
#(
    parameter int N_IRQ = 256
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CORES-1:0][N_IRQ-1:0]   st_d,
    input  sel_t [N_IRQ/GRP_BITS-1:0]     pin,
    output logic [CORES*PINS-1:0]         irq_out
);
    localparam int GRPS = N_IRQ / GRP_BITS;

    logic [CORES*PINS-1:0] out_d;

    always_comb begin
        out_d = '0;
        for (int c = 0; c < CORES; c++) begin
            for (int g = 0; g < GRPS; g++) begin
                if (|st_d[c][g*GRP_BITS +: GRP_BITS])
                    out_d[c*PINS + int'(pin[g])] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_out <= '0;
        else     irq_out <= out_d;
    end

endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
    import exir_pkg::*;
#(
    parameter int N_IRQ      = 256,
    parameter int NODE_WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_IRQ-1:0]        irq_in,
    input  logic [11:0]             reg_addr,
    input  logic                    reg_wen,
    input  logic [31:0]             reg_wdata,
    input  logic [1:0]              reg_core,
    output logic [31:0]             reg_rdata,
    output logic [15:0]             irq_out
);
    localparam int GRPS = N_IRQ / GRP_BITS;

    logic [N_IRQ-1:0]            en_q, en_d, clr_mask;
    sel_t [N_IRQ-1:0]            tgt_q, tgt_d;
    sel_t [GRPS-1:0]             pin;
    logic                        clr_vld;
    logic [CORES-1:0][N_IRQ-1:0] st_q, st_d;

    exir_regs #(.N_IRQ(N_IRQ), .NODE_WORDS(NODE_WORDS)) u_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_core(reg_core), .st_q(st_q),
        .en_q(en_q), .en_d(en_d), .tgt_q(tgt_q), .tgt_d(tgt_d), .pin(pin),
        .clr_vld(clr_vld), .clr_mask(clr_mask), .reg_rdata(reg_rdata)
    );

    exir_status #(.N_IRQ(N_IRQ)) u_status (
        .clk(clk), .rst(rst), .irq_in(irq_in), .en_q(en_q), .en_d(en_d),
        .tgt_q(tgt_q), .tgt_d(tgt_d), .clr_vld(clr_vld), .clr_core(reg_core),
        .clr_mask(clr_mask), .st_q(st_q), .st_d(st_d)
    );

    exir_fanin #(.N_IRQ(N_IRQ)) u_fanin (
        .clk(clk), .rst(rst), .st_d(st_d), .pin(pin), .irq_out(irq_out)
    );

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == '0) |-> (irq_out == '0));

endmodule

// File: tb/test_ext_irq_router.sv
`timescale 1ns/1ps
module test_ext_irq_router;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] irq_in = '0;
    logic [11:0]  reg_addr = '0;
    logic         reg_wen = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [1:0]   reg_core = '0;
    logic [31:0]  reg_rdata;
    logic [15:0]  irq_out;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ext_irq_router i_ext_irq_router (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_core(reg_core),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] core);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_core = core; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] core, output logic [31:0] d);
        reg_addr = a; reg_core = core;
        #1 d = reg_rdata;
    endtask

    task automatic line(input int idx, input logic v);
        @(negedge clk);
        irq_in[idx] = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 outputs", 32'(irq_out), 32'h0);
        rd(12'h100, 2'd0, d); chk("R1 enable word", d, 32'h0);
        rd(12'h820, 2'd0, d); chk("R1 core map", d, 32'h0);
        rd(12'h200, 2'd0, d); chk("R1 pin map", d, 32'h0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        wr(12'h100, 32'hFFFF_FFFF, 2'd0);
        line(5, 1'b1);
        chk("R5 raise enabled", 32'(irq_out), 32'h0001);
        rd(12'h400, 2'd0, d); chk("R2 status bit 5", d, 32'h0000_0020);
        line(5, 1'b0);
        chk("R6 fall output", 32'(irq_out), 32'h0);
        rd(12'h400, 2'd0, d); chk("R6 status cleared", d, 32'h0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        line(40, 1'b1);
        chk("R5 masked line quiet", 32'(irq_out), 32'h0);
        rd(12'h404, 2'd0, d); chk("R5 masked status", d, 32'h0);
        wr(12'h104, 32'h0000_0100, 2'd0);
        chk("R8 unmask raises", 32'(irq_out), 32'h0001);
        rd(12'h404, 2'd0, d); chk("R8 status after unmask", d, 32'h0000_0100);
        wr(12'h104, 32'h0, 2'd0);
        chk("R8 mask lowers", 32'(irq_out), 32'h0);
        line(40, 1'b0);
    endtask

    task automatic t_pin_core;
        logic [31:0] d;
        wr(12'h200, 32'h0830_0400, 2'd0);
        wr(12'h104, 32'hFFFF_FFFF, 2'd0);
        wr(12'h108, 32'hFFFF_FFFF, 2'd0);
        wr(12'h10C, 32'h0000_0001, 2'd0);
        wr(12'h820, 32'hF000_0200, 2'd0);
        rd(12'h200, 2'd0, d); chk("R3 pin map readback", d, 32'h0830_0400);
        line(33, 1'b1);
        chk("R4 core1 pin2", 32'(irq_out), 32'h0040);
        line(64, 1'b1);
        chk("R3 fallback pin0", 32'(irq_out), 32'h0041);
        line(33, 1'b0); line(64, 1'b0);
        line(35, 1'b1);
        chk("R4 fallback core0", 32'(irq_out), 32'h0004);
        line(35, 1'b0);
        line(96, 1'b1);
        chk("R3 pin3", 32'(irq_out), 32'h0008);
        line(96, 1'b0);
        chk("R6 all low", 32'(irq_out), 32'h0);
    endtask

    task automatic t_or;
        line(1, 1'b1); line(2, 1'b1);
        chk("R7 two lines", 32'(irq_out), 32'h0001);
        line(1, 1'b0);
        chk("R7 one remains", 32'(irq_out), 32'h0001);
        line(2, 1'b0);
        chk("R7 last leaves", 32'(irq_out), 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        line(3, 1'b1);
        rd(12'h400, 2'd0, d); chk("R9 status set", d, 32'h0000_0008);
        wr(12'h400, 32'h0000_0008, 2'd1);
        chk("R9 other core write", 32'(irq_out), 32'h0001);
        rd(12'h400, 2'd0, d); chk("R9 core0 untouched", d, 32'h0000_0008);
        wr(12'h400, 32'h0000_0008, 2'd0);
        chk("R9 cleared output", 32'(irq_out), 32'h0);
        rd(12'h400, 2'd0, d); chk("R9 cleared status", d, 32'h0);
        line(3, 1'b0);
    endtask

    task automatic t_move;
        logic [31:0] d;
        line(4, 1'b1);
        chk("R10 before move", 32'(irq_out), 32'h0001);
        wr(12'h804, 32'h0004_0008, 2'd0);
        chk("R10 moved to core3", 32'(irq_out), 32'h1000);
        rd(12'h400, 2'd3, d); chk("R10 core3 status", d, 32'h0000_0010);
        rd(12'h400, 2'd0, d); chk("R10 core0 status", d, 32'h0);
        line(6, 1'b1);
        chk("R4 core2 idle remap", 32'(irq_out), 32'h1100);
        line(4, 1'b0); line(6, 1'b0);
    endtask

    task automatic t_prio;
        logic [31:0] d;
        @(negedge clk);
        irq_in[9] = 1'b1;
        reg_addr = 12'h400; reg_wdata = 32'h0000_0200; reg_core = 2'd0; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
        chk("R12 line wins output", 32'(irq_out), 32'h0001);
        rd(12'h400, 2'd0, d); chk("R12 line wins status", d, 32'h0000_0200);
        line(9, 1'b0);
    endtask

    task automatic t_storage;
        logic [31:0] d;
        wr(12'h300, 32'hA5A5_0001, 2'd0);
        wr(12'h004, 32'h0000_1234, 2'd0);
        rd(12'h300, 2'd0, d); chk("R11 bounce word", d, 32'hA5A5_0001);
        rd(12'h004, 2'd0, d); chk("R11 node word", d, 32'h0000_1234);
        chk("R11 no routing effect", 32'(irq_out), 32'h0);
        rd(12'h600, 2'd0, d); chk("R11 unmapped 0x600", d, 32'h0);
        rd(12'hC00, 2'd0, d); chk("R11 unmapped 0xC00", d, 32'h0);
        rd(12'h010, 2'd0, d); chk("R11 past node words", d, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_enable();
        t_pin_core();
        t_or();
        t_w1c();
        t_move();
        t_prio();
        t_storage();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule